// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a processor core and inspects every bus access the core makes. Software programs two comparison channels, A and B. Each channel has a target address with a per-bit ignore mask, an address-space identifier that can be excluded from the comparison, and a pair of access-type enables. Channel B can additionally compare the data bus value under a per-bit ignore mask. When an access satisfies a channel, that channel's match flag is recorded and, unless the core currently blocks exceptions, a one-cycle break request is raised toward the core.

The two channels either act on their own or form an ordered pair. In the ordered pair, a channel A hit is only remembered, and the break is raised later on the access that satisfies channel B. A companion output tells the core whether an instruction-fetch break must be taken before the matching instruction executes or after it. Match flags stay set until software clears them through the control register.

Top module: `bkpt_unit`

## Requirements
- R1: After reset all configuration and control registers are zero, both match flags are 0, `brk_req` and `brk_before` are 0, and no access causes a break because every access-type field is zero.
- R2: The condition register (select 3 for A, 6 for B) holds an access-kind field in bits [1:0] (bit 0 enables instruction fetches, bit 1 enables operand accesses), a direction field in bits [3:2] (bit 2 enables reads, bit 3 enables writes), an identifier-ignore bit in bit 4 and the identifier in bits [15:8]; a channel matches only if the enable bit for the access's kind and for its direction are both 1, so a zero field disables the channel.
- R3: A channel's address (select 1 for A, 4 for B) is compared with the bus address on every bit whose ignore-mask bit (select 2 for A, 5 for B) is 0; bits with mask 1 are not compared.
- R4: When the identifier-ignore bit is 0 the bus identifier must equal the programmed identifier; when it is 1 the identifier is not compared.
- R5: With control bit 5 set, channel B also requires the bus data to equal the data register (select 7) on every bit whose data-mask bit (select 8) is 0; with bit 5 clear, and always for channel A, data is not compared.
- R6: A channel that breaks sets its match flag (control bits 0 for A and 1 for B, also output on ports); flags are never cleared by hardware, a control write (select 0) clears each flag whose written bit is 0, writing 1 leaves it unchanged, and a hit in the same cycle as the write wins.
- R7: While `cpu_block` is 1 during a satisfying access the flag is still set but `brk_req` stays 0.
- R8: With control bit 2 set (ordered mode), a channel A hit raises no break and no flag but arms the unit; a later channel B hit while armed raises the break, sets only the B flag and disarms; a B hit while not armed does nothing.
- R9: In ordered mode, an access satisfying both channels while not armed only arms the unit; the break needs a later B hit.
- R10: A control write with bit 2 clear discards an armed channel A hit, so re-entering ordered mode requires a new A hit.
- R11: `brk_req` is a one-cycle pulse in the cycle after the access's `bus_valid` cycle; `brk_before` pulses with it and is 1 only for an instruction fetch whose breaking channel has its post-execution bit clear (control bit 3 for A, bit 4 for B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_addr | input | ADDR_W | Access address |
| bus_asid | input | ASID_W | Access address-space identifier |
| bus_is_operand | input | 1 | 1 operand access, 0 instruction fetch |
| bus_is_write | input | 1 | 1 write, 0 read |
| bus_data | input | DATA_W | Access data value |
| cpu_block | input | 1 | Core exception block bit |
| brk_req | output | 1 | Break exception request pulse |
| brk_before | output | 1 | Break is to be taken before the instruction executes |
| match_flag_a | output | 1 | Sticky channel A match flag |
| match_flag_b | output | 1 | Sticky channel B match flag |

## Verification
The access-type fields are swept over all sixteen kind/direction settings against all four access shapes, which separates each enable bit from the others and confirms that a zero field disables a channel. Address and data comparisons are tried with single-bit flips walked across masked and unmasked positions, telling a correct mask from an inverted or shifted one, and the identifier is tried equal, off by one bit and fully different with and without the ignore bit. Ordered mode is driven with B-only, A-then-B, both-at-once and A-then-cancel-then-B patterns, which distinguish arming, firing, same-access handling and discarding. Flag clearing, the block bit and the before/after indication are each tried in both polarities.

// File: rtl/bkpt_pkg.sv
// Package: register selects and field positions shared by the
// breakpoint unit and its submodules.
package bkpt_pkg;

    typedef enum logic [3:0] {
        SEL_CTRL    = 4'd0,
        SEL_A_ADDR  = 4'd1,
        SEL_A_AMASK = 4'd2,
        SEL_A_COND  = 4'd3,
        SEL_B_ADDR  = 4'd4,
        SEL_B_AMASK = 4'd5,
        SEL_B_COND  = 4'd6,
        SEL_B_DATA  = 4'd7,
        SEL_B_DMASK = 4'd8
    } reg_sel_e;

    // Control register bit positions (flag bits match channel index)
    localparam int CTL_FLAG_A = 0;
    localparam int CTL_FLAG_B = 1;
    localparam int CTL_SEQ    = 2;
    localparam int CTL_POST_A = 3;
    localparam int CTL_POST_B = 4;
    localparam int CTL_DATA_B = 5;

    // Condition register field positions
    localparam int COND_KIND_LSB = 0;
    localparam int COND_DIR_LSB  = 2;
    localparam int COND_ASID_IGN = 4;
    localparam int COND_ASID_LSB = 8;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/bkpt_regs.sv
// Module: configuration and control register file of the breakpoint unit.
// Holds both channels' address, mask and condition registers, channel B's
// data and data mask, the control bits and the sticky match flags.
// Assumes DATA_W >= ADDR_W and DATA_W >= COND_ASID_LSB + ASID_W.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [3:0]                      wr_sel,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [NUM_CH-1:0]               set_flag,
    output logic [NUM_CH-1:0][ADDR_W-1:0]   ch_addr,
    output logic [NUM_CH-1:0][ADDR_W-1:0]   ch_amask,
    output logic [NUM_CH-1:0][ASID_W-1:0]   ch_asid,
    output logic [NUM_CH-1:0]               ch_asid_ign,
    output logic [NUM_CH-1:0][1:0]          ch_kind,
    output logic [NUM_CH-1:0][1:0]          ch_dir,
    output logic [DATA_W-1:0]               b_data,
    output logic [DATA_W-1:0]               b_dmask,
    output logic                            seq_en,
    output logic [NUM_CH-1:0]               post_exec,
    output logic                            data_en,
    output logic [NUM_CH-1:0]               flag,
    output logic                            seq_drop
);

    logic ctrl_wr;

    // Decode a write to the control register and a sequence cancel
    always_comb begin
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
        seq_drop = ctrl_wr && !wr_data[CTL_SEQ];
    end

    // Per-channel comparison registers, replicated for each channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = (c == 0) ? int'(SEL_A_ADDR) : int'(SEL_B_ADDR);

        // Load address, mask and condition fields on a matching select
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr[c]     <= '0;
                ch_amask[c]    <= '0;
                ch_asid[c]     <= '0;
                ch_asid_ign[c] <= 1'b0;
                ch_kind[c]     <= 2'b00;
                ch_dir[c]      <= 2'b00;
            end else if (wr_en) begin
                if (wr_sel == 4'(BASE))
                    ch_addr[c] <= wr_data[ADDR_W-1:0];
                if (wr_sel == 4'(BASE + 1))
                    ch_amask[c] <= wr_data[ADDR_W-1:0];
                if (wr_sel == 4'(BASE + 2)) begin
                    ch_kind[c]     <= wr_data[COND_KIND_LSB +: 2];
                    ch_dir[c]      <= wr_data[COND_DIR_LSB +: 2];
                    ch_asid_ign[c] <= wr_data[COND_ASID_IGN];
                    ch_asid[c]     <= wr_data[COND_ASID_LSB +: ASID_W];
                end
            end
        end

        // R6: a flag falls only through a control write with a zero in its bit
        a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[c]) |-> $past(ctrl_wr && !wr_data[c]));
    end

    // Load channel B data value and data mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_data  <= '0;
            b_dmask <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_B_DATA)  b_data  <= wr_data;
            if (wr_sel == SEL_B_DMASK) b_dmask <= wr_data;
        end
    end

    // Load the mode bits of the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_en    <= 1'b0;
            post_exec <= '0;
            data_en   <= 1'b0;
        end else if (ctrl_wr) begin
            seq_en       <= wr_data[CTL_SEQ];
            post_exec[0] <= wr_data[CTL_POST_A];
            post_exec[1] <= wr_data[CTL_POST_B];
            data_en      <= wr_data[CTL_DATA_B];
        end
    end

    // Sticky flags: hardware sets, software write clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                flag[c] <= (ctrl_wr ? (flag[c] & wr_data[c]) : flag[c]) | set_flag[c];
            end
        end
    end

endmodule

// File: rtl/bkpt_match.sv
// Module: single-channel comparator. Evaluates whether the current bus
// access satisfies one channel's programmed condition. The data compare
// is built only when HAS_DATA is 1. Purely combinational; it does not
// look at the valid strobe.
module bkpt_match #(
    parameter int ADDR_W   = 32,
    parameter int ASID_W   = 8,
    parameter int DATA_W   = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_amask,
    input  logic [ASID_W-1:0] cfg_asid,
    input  logic              cfg_asid_ign,
    input  logic [1:0]        cfg_kind,
    input  logic [1:0]        cfg_dir,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_dmask,
    input  logic              cfg_data_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic              bus_is_operand,
    input  logic              bus_is_write,
    input  logic [DATA_W-1:0] bus_data,
    output logic              hit
);

    logic kind_ok, dir_ok, addr_ok, asid_ok, data_ok;

    // Access-type, address and identifier qualification
    always_comb begin
        kind_ok = bus_is_operand ? cfg_kind[1] : cfg_kind[0];
        dir_ok  = bus_is_write   ? cfg_dir[1]  : cfg_dir[0];
        addr_ok = ((bus_addr ^ cfg_addr) & ~cfg_amask) == '0;
        asid_ok = cfg_asid_ign || (bus_asid == cfg_asid);
    end

    if (HAS_DATA) begin : g_data
        // Masked data comparison, active only when enabled
        always_comb begin
            data_ok = !cfg_data_en || (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);
        end
    end else begin : g_nodata
        logic unused_data;
        // Data inputs are present for a uniform interface only
        always_comb begin
            unused_data = ^{cfg_data, cfg_dmask, cfg_data_en, bus_data};
            data_ok     = 1'b1;
        end
    end

    // Combine all qualifiers into the channel hit
    always_comb begin
        hit = kind_ok && dir_ok && addr_ok && asid_ok && data_ok;
    end

    // R2: a zero kind or direction field never yields a hit
    always_comb begin
        a_r2_field_zero_off: assert ((cfg_kind != 2'b00 && cfg_dir != 2'b00) || !hit);
    end

endmodule

// File: rtl/bkpt_seq.sv
// Module: break sequencer. Turns the two channel hits into flag-set
// strobes and a registered break request, implementing the independent
// and the ordered (A then B) modes and the exception block.
// Assumes hit inputs are meaningful only when bus_valid is 1.
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_is_operand,
    input  logic              cpu_block,
    input  logic              seq_en,
    input  logic              seq_drop,
    input  logic [NUM_CH-1:0] post_exec,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] set_flag,
    output logic              brk_req,
    output logic              brk_before
);

    logic armed_q;
    logic fire;
    logic before_n;

    // Decide which channels break on this access
    always_comb begin
        set_flag[0] = bus_valid && hit[0] && !seq_en;
        set_flag[1] = bus_valid && hit[1] && (!seq_en || armed_q);
        fire        = |set_flag;
        before_n    = !bus_is_operand &&
                      ((set_flag[0] && !post_exec[0]) || (set_flag[1] && !post_exec[1]));
    end

    // Remember a channel A hit in ordered mode until B hits or it is cancelled
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (seq_drop || !seq_en)
            armed_q <= 1'b0;
        else if (bus_valid)
            armed_q <= hit[0] || (armed_q && !hit[1]);
    end

    // Register the break request and the before/after indication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req    <= 1'b0;
            brk_before <= 1'b0;
        end else begin
            brk_req    <= fire && !cpu_block;
            brk_before <= fire && !cpu_block && before_n;
        end
    end

    // R11: a request follows an unblocked valid access by one cycle
    a_r11_req_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid && !cpu_block));

    // R11: the before indication only accompanies a request
    a_r11_before_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        brk_before |-> brk_req);

    // R7: a blocked access never produces a request
    a_r7_block_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cpu_block) |=> !brk_req);

    // R8: in ordered mode an unarmed access cannot break
    a_r8_unarmed_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && seq_en && !armed_q) |=> !brk_req);

endmodule

// File: rtl/bkpt_unit.sv
// Module: two-channel bus breakpoint unit (top). Connects the register
// file, one comparator per channel (data compare on channel B only) and
// the sequencer. Assumes DATA_W covers ADDR_W and the condition fields.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic              bus_is_operand,
    input  logic              bus_is_write,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cpu_block,
    output logic              brk_req,
    output logic              brk_before,
    output logic              match_flag_a,
    output logic              match_flag_b
);

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [NUM_CH-1:0][ADDR_W-1:0] ch_amask;
    logic [NUM_CH-1:0][ASID_W-1:0] ch_asid;
    logic [NUM_CH-1:0]             ch_asid_ign;
    logic [NUM_CH-1:0][1:0]        ch_kind;
    logic [NUM_CH-1:0][1:0]        ch_dir;
    logic [DATA_W-1:0]             b_data;
    logic [DATA_W-1:0]             b_dmask;
    logic                          seq_en;
    logic [NUM_CH-1:0]             post_exec;
    logic                          data_en;
    logic [NUM_CH-1:0]             flag;
    logic                          seq_drop;
    logic [NUM_CH-1:0]             set_flag;
    logic [NUM_CH-1:0]             hit;

    bkpt_regs #(
        .ADDR_W (ADDR_W),
        .ASID_W (ASID_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_sel      (cfg_sel),
        .wr_data     (cfg_wdata),
        .set_flag    (set_flag),
        .ch_addr     (ch_addr),
        .ch_amask    (ch_amask),
        .ch_asid     (ch_asid),
        .ch_asid_ign (ch_asid_ign),
        .ch_kind     (ch_kind),
        .ch_dir      (ch_dir),
        .b_data      (b_data),
        .b_dmask     (b_dmask),
        .seq_en      (seq_en),
        .post_exec   (post_exec),
        .data_en     (data_en),
        .flag        (flag),
        .seq_drop    (seq_drop)
    );

    // One comparator per channel; only channel B carries the data compare
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        bkpt_match #(
            .ADDR_W   (ADDR_W),
            .ASID_W   (ASID_W),
            .DATA_W   (DATA_W),
            .HAS_DATA (c == 1)
        ) u_match (
            .cfg_addr       (ch_addr[c]),
            .cfg_amask      (ch_amask[c]),
            .cfg_asid       (ch_asid[c]),
            .cfg_asid_ign   (ch_asid_ign[c]),
            .cfg_kind       (ch_kind[c]),
            .cfg_dir        (ch_dir[c]),
            .cfg_data       (b_data),
            .cfg_dmask      (b_dmask),
            .cfg_data_en    (data_en),
            .bus_addr       (bus_addr),
            .bus_asid       (bus_asid),
            .bus_is_operand (bus_is_operand),
            .bus_is_write   (bus_is_write),
            .bus_data       (bus_data),
            .hit            (hit[c])
        );
    end

    bkpt_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_valid      (bus_valid),
        .bus_is_operand (bus_is_operand),
        .cpu_block      (cpu_block),
        .seq_en         (seq_en),
        .seq_drop       (seq_drop),
        .post_exec      (post_exec),
        .hit            (hit),
        .set_flag       (set_flag),
        .brk_req        (brk_req),
        .brk_before     (brk_before)
    );

    // Expose the sticky flags
    always_comb begin
        match_flag_a = flag[0];
        match_flag_b = flag[1];
    end

    // R6: a flag rises only after a valid access
    a_r6_flag_rise_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(match_flag_a) || $rose(match_flag_b)) |-> $past(bus_valid));

    // R8: in ordered mode the A flag is never set by hardware
    a_r8_no_a_flag_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && seq_en) |=> !$rose(match_flag_a));

    // R2: with both channels disabled by their type fields, no request follows
    a_r2_both_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (ch_kind[0] == 2'b00) && (ch_kind[1] == 2'b00)) |=> !brk_req);

endmodule

// File: tb/bkpt_unit_tb.sv
`timescale 1ns/1ps
module bkpt_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_asid = '0;
    logic        bus_is_operand = 1'b0;
    logic        bus_is_write = 1'b0;
    logic [31:0] bus_data = '0;
    logic        cpu_block = 1'b0;
    logic        brk_req, brk_before, match_flag_a, match_flag_b;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bkpt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_asid(bus_asid), .bus_is_operand(bus_is_operand),
        .bus_is_write(bus_is_write), .bus_data(bus_data), .cpu_block(cpu_block),
        .brk_req(brk_req), .brk_before(brk_before),
        .match_flag_a(match_flag_a), .match_flag_b(match_flag_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] s, input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Present one access; on return the registered result is visible
    task automatic acc(input logic [31:0] a, input logic [7:0] id, input logic op,
                       input logic w, input logic [31:0] d, input logic blk);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_asid = id;
        bus_is_operand = op; bus_is_write = w; bus_data = d; cpu_block = blk;
        @(negedge clk);
        bus_valid = 1'b0; cpu_block = 1'b0;
    endtask

    function automatic logic [31:0] cond(input logic [1:0] k, input logic [1:0] d,
                                         input logic ign, input logic [7:0] id);
        return {16'h0, id, 3'b000, ign, d, k};
    endfunction

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req", brk_req, 0);
        chk("R1 before", brk_before, 0);
        chk("R1 flags", {match_flag_b, match_flag_a}, 0);
        acc(32'h0, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R1 disabled req", brk_req, 0);
        acc(32'h0, 8'h0, 1'b1, 1'b1, 32'h0, 1'b0);
        chk("R1 disabled flags", {match_flag_b, match_flag_a}, 0);

        // R2 sweep: all kind/dir fields against all access shapes on channel A
        wreg(4'd1, 32'h100);
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 4; d++) begin
                wreg(4'd3, cond(2'(k), 2'(d), 1'b1, 8'h0));
                for (int op = 0; op < 2; op++) begin
                    for (int w = 0; w < 2; w++) begin
                        wreg(4'd0, 32'h0);
                        acc(32'h100, 8'h33, op[0], w[0], 32'h0, 1'b0);
                        e = (op[0] ? k[1] : k[0]) & (w[0] ? d[1] : d[0]);
                        chk("R2 req", brk_req, e);
                        chk("R6 flag_a", match_flag_a, e);
                        chk("R11 before", brk_before, e & ~op[0]);
                        @(negedge clk);
                        chk("R11 pulse", brk_req, 0);
                    end
                end
            end
        end

        // R3: address mask, walk one flipped bit across positions
        wreg(4'd3, cond(2'b11, 2'b11, 1'b1, 8'h0));
        wreg(4'd2, 32'h0F0);
        for (int i = 0; i < 12; i++) begin
            wreg(4'd0, 32'h0);
            acc(32'h100 ^ (32'h1 << i), 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
            chk("R3 addr mask", brk_req, (i >= 4 && i <= 7) ? 1 : 0);
        end
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R3 exact", brk_req, 1);

        // R4: identifier compare and ignore
        wreg(4'd2, 32'h0);
        wreg(4'd3, cond(2'b11, 2'b11, 1'b0, 8'h5A));
        acc(32'h100, 8'h5A, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R4 asid equal", brk_req, 1);
        acc(32'h100, 8'h5B, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R4 asid one bit", brk_req, 0);
        acc(32'h100, 8'hA5, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R4 asid other", brk_req, 0);
        wreg(4'd3, cond(2'b11, 2'b11, 1'b1, 8'h5A));
        acc(32'h100, 8'hA5, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R4 asid ignored", brk_req, 1);

        // R5: channel B data compare with mask
        wreg(4'd3, 32'h0);
        wreg(4'd4, 32'h200);
        wreg(4'd5, 32'h0);
        wreg(4'd6, cond(2'b11, 2'b11, 1'b1, 8'h0));
        wreg(4'd7, 32'h1234_5678);
        wreg(4'd8, 32'h0000_FF00);
        for (int i = 0; i < 16; i++) begin
            wreg(4'd0, 32'h20);
            acc(32'h200, 8'h0, 1'b1, 1'b1, 32'h1234_5678 ^ (32'h1 << i), 1'b0);
            e = (i >= 8) ? 1'b1 : 1'b0;
            chk("R5 data mask req", brk_req, e);
            chk("R5 data mask flag_b", match_flag_b, e);
        end
        wreg(4'd0, 32'h0);
        acc(32'h200, 8'h0, 1'b1, 1'b1, 32'hFFFF_0000, 1'b0);
        chk("R5 data disabled", brk_req, 1);
        wreg(4'd3, cond(2'b11, 2'b11, 1'b1, 8'h0));
        wreg(4'd0, 32'h20);
        acc(32'h100, 8'h0, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0);
        chk("R5 channel A ignores data", brk_req, 1);
        chk("R5 flag_a", match_flag_a, 1);

        // R6: stickiness and software clear
        acc(32'h999, 8'h0, 1'b1, 1'b1, 32'h0, 1'b0);
        chk("R6 held req", brk_req, 0);
        chk("R6 held flag", match_flag_a, 1);
        wreg(4'd0, 32'h3);
        chk("R6 write one keeps", match_flag_a, 1);
        wreg(4'd0, 32'h0);
        chk("R6 write zero clears", match_flag_a, 0);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = 4'd0; cfg_wdata = 32'h0;
        bus_valid = 1'b1; bus_addr = 32'h100; bus_is_operand = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; bus_valid = 1'b0;
        chk("R6 set wins", match_flag_a, 1);
        wreg(4'd0, 32'h0);

        // R7: block bit
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b1);
        chk("R7 blocked req", brk_req, 0);
        chk("R7 blocked flag", match_flag_a, 1);
        wreg(4'd0, 32'h0);

        // R8: ordered mode
        wreg(4'd0, 32'h4);
        acc(32'h200, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R8 B alone req", brk_req, 0);
        chk("R8 B alone flag", match_flag_b, 0);
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R8 A arm req", brk_req, 0);
        chk("R8 A arm flag", match_flag_a, 0);
        acc(32'h200, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R8 fire req", brk_req, 1);
        chk("R8 fire flags", {match_flag_b, match_flag_a}, 2);
        acc(32'h200, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R8 disarmed", brk_req, 0);

        // R9: both channels on one access
        wreg(4'd4, 32'h100);
        wreg(4'd0, 32'h4);
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R9 same access", brk_req, 0);
        chk("R9 same access flags", {match_flag_b, match_flag_a}, 0);
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R9 later B", brk_req, 1);
        chk("R9 only B flag", {match_flag_b, match_flag_a}, 2);

        // R10: cancel an armed A hit
        wreg(4'd4, 32'h200);
        wreg(4'd0, 32'h4);
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        wreg(4'd0, 32'h0);
        wreg(4'd0, 32'h4);
        acc(32'h200, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R10 cancelled", brk_req, 0);
        acc(32'h100, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        acc(32'h200, 8'h0, 1'b1, 1'b0, 32'h0, 1'b0);
        chk("R10 re-armed", brk_req, 1);

        // R11: post-execution bits per channel
        wreg(4'd0, 32'h8);
        acc(32'h100, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R11 A post req", brk_req, 1);
        chk("R11 A post before", brk_before, 0);
        wreg(4'd0, 32'h0);
        acc(32'h100, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R11 A pre before", brk_before, 1);
        wreg(4'd0, 32'h10);
        acc(32'h200, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R11 B post before", brk_before, 0);
        chk("R11 B post req", brk_req, 1);
        wreg(4'd0, 32'h8);
        acc(32'h200, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0);
        chk("R11 B pre before", brk_before, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule